// File: doc/BRIEF.md
# Scan Conversion Sequencer with Clock Stretch

This block controls the conversions of a serial-bus analog-to-digital slave that runs on its own internal conversion clock. It sees the bus only as decoded events: a pulse when a read address has matched, and one pulse for each rising and each falling SCL edge. From these it tells the converter core when to track the input and when to sample and start. It then walks a list of channels and starts one conversion after another while it holds SCL low. Each conversion finishes with a done pulse from the core. For each done pulse the block writes one result strobe with a running index. It lets SCL go only when the last conversion of the list is finished.

Software writes a configuration word through a load strobe. The word holds a start channel, a two-bit scan type, a reference-pin bit, a clock-mode bit, a single-ended bit and a bipolar bit. When the reference-pin bit is set, the top analog channel serves as the reference pin and is left out of multichannel scans. The coding request to the converter is always unipolar for single-ended inputs.

Top module: `scan_seq_top`

## Requirements
- R1: After a synchronous active-low reset, `clk_mode` reads 0 (internal clock mode), and `scl_hold`, `track` and `conv_start` are low.
- R2: `track` stays low through the 7th `scl_rise` pulse after an accepted `addr_rd_hit`. It goes high in the cycle after the 8th `scl_rise` pulse.
- R3: In the cycle after the 9th `scl_fall` pulse that follows an accepted `addr_rd_hit`, the outputs change together. `track` goes low, `scl_hold` goes high, and `conv_start` pulses for one cycle with `ch_sel` set to the first channel of the list.
- R4: `scl_hold` stays high in every cycle from the first `conv_start` of a scan until the cycle of its last `res_we`.
- R5: Conversions run back to back. In the cycle after each `conv_done`, `res_we` pulses with `res_idx` counting 0, 1, 2 and so on. If more conversions remain, `conv_start` pulses in that same cycle with `ch_sel` set to the next channel in the list.
- R6: `scl_hold` goes low in the same cycle as the `res_we` of the last conversion, and not earlier.
- R7: The scan type (`cfg_scan_type`) sets the channel list, with `ch_sel` carrying the binary channel number. The encodings are:
  - 00: channels 0 up to the start channel.
  - 01: the start channel converted 8 times.
  - 10: the start channel up to the top channel.
  - 11: the start channel converted once.
- R8: With `cfg_ref_pin`=1, channel 3 is left out of scan types 00 and 10, so channel 2 is the highest channel they convert. Type 00 with start 3 converts 0,1,2. Type 10 with start 1 converts 1,2.
- R9: `unipolar` is 1 whenever `cfg_single_ended`=1. Otherwise it is the inverse of `cfg_bipolar`.
- R10: From an accepted address until `scl_hold` is released, the block ignores both `addr_rd_hit` and `cfg_load`. Neither a new scan nor a new configuration results from them.
- R11: With `clk_mode`=1 (loaded from `cfg_clk_ext`), an `addr_rd_hit` starts nothing: `track` and `conv_start` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the configuration fields |
| cfg_start_ch | input | 2 | Start channel |
| cfg_scan_type | input | 2 | Scan type (see R7) |
| cfg_ref_pin | input | 1 | Top channel used as reference pin |
| cfg_clk_ext | input | 1 | Clock-mode bit, 1 = external |
| cfg_single_ended | input | 1 | 1 = single-ended inputs |
| cfg_bipolar | input | 1 | 1 = bipolar coding for differential inputs |
| addr_rd_hit | input | 1 | Pulse: valid read address matched |
| scl_rise | input | 1 | Pulse per SCL rising edge |
| scl_fall | input | 1 | Pulse per SCL falling edge |
| conv_done | input | 1 | Pulse from the converter core: conversion finished |
| clk_mode | output | 1 | Registered clock-mode bit |
| unipolar | output | 1 | Coding request to the converter core |
| track | output | 1 | Track/hold control, 1 = tracking |
| ch_sel | output | 2 | Channel for the current conversion |
| conv_start | output | 1 | One-cycle convert-start strobe |
| scl_hold | output | 1 | 1 = hold SCL low |
| res_we | output | 1 | Result write strobe |
| res_idx | output | 3 | Result storage index |

## Verification
Each of the four scan types is run with start channels and reference-pin settings that tell an inclusive bound from an exclusive one. The cases where the reference pin clips channel 3 are set against the case where it does not, for both a rising and a falling walk. A repeated scan of eight conversions checks the index count and the back-to-back restart. Single conversions on channel 0 and channel 3 check that repeat and single types are never clipped.

The bench counts edges one by one around the 7th and 8th rising edges and the 9th falling edge. A track or sample that is off by one edge shows up there. A second address, a full run of SCL edges and a configuration load are all sent in the middle of a scan. The scan must still stop after its own list and the register must keep its old clock-mode bit. With the clock-mode bit set to external, an address must start nothing.

// File: rtl/scan_pkg.sv
// Shared types of the scan sequencer.
// Assumes: the scan type is a 2-bit field whose codes are decoded by the walker.
package scan_pkg;

    typedef enum logic [1:0] {
        SCAN_UPTO   = 2'b00,
        SCAN_REPEAT = 2'b01,
        SCAN_FROM   = 2'b10,
        SCAN_SINGLE = 2'b11
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e mode;
        logic       ref_pin;
        logic       clk_ext;
        logic       single_ended;
        logic       bipolar;
    } cfg_flags_t;

endpackage

// File: rtl/scan_cfg_reg.sv
// Configuration register of the sequencer.
// Captures the fields on a load strobe, but only while no scan is busy.
// Drives the clock-mode bit and the coding request from the held copy.
// Assumes: the load strobe is one cycle wide.
module scan_cfg_reg
    import scan_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            busy,
    input  logic [CH_W-1:0] start_in,
    input  cfg_flags_t      flags_in,
    output logic [CH_W-1:0] start_q,
    output cfg_flags_t      flags_q,
    output logic            clk_mode,
    output logic            unipolar
);

    // hold the configuration; after reset it is internal clock mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            flags_q <= '{mode: SCAN_SINGLE, ref_pin: 1'b0, clk_ext: 1'b0,
                         single_ended: 1'b1, bipolar: 1'b0};
        end else if (load && !busy) begin
            start_q <= start_in;
            flags_q <= flags_in;
        end
    end

    // derived outputs
    always_comb begin
        clk_mode = flags_q.clk_ext;
        unipolar = flags_q.single_ended | ~flags_q.bipolar;
    end

    // R9
    uni_se_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.single_ended |-> unipolar);

endmodule

// File: rtl/scan_edge_trig.sv
// Counts SCL edges after an accepted read address.
// Raises track on the TRACK_RISE-th rising edge.
// Gives a one-cycle sample pulse on the SAMPLE_FALL-th falling edge.
// Assumes: address and edge pulses never coincide, and each is one cycle wide.
module scan_edge_trig #(
    parameter int TRACK_RISE  = 8,
    parameter int SAMPLE_FALL = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic scl_rise,
    input  logic scl_fall,
    output logic armed,
    output logic track,
    output logic sample_go
);

    localparam int CNT_W = $clog2(SAMPLE_FALL + 1);

    logic [CNT_W-1:0] rise_cnt;
    logic [CNT_W-1:0] fall_cnt;
    logic             track_go;

    // decode the target edges
    always_comb begin
        track_go  = armed && scl_rise && (rise_cnt == CNT_W'(TRACK_RISE - 1));
        sample_go = armed && scl_fall && (fall_cnt == CNT_W'(SAMPLE_FALL - 1));
    end

    // arm on start; count edges while armed; disarm at the sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            rise_cnt <= '0;
            fall_cnt <= '0;
        end else if (start) begin
            armed    <= 1'b1;
            rise_cnt <= '0;
            fall_cnt <= '0;
        end else if (armed) begin
            if (sample_go)
                armed <= 1'b0;
            if (scl_rise && rise_cnt != CNT_W'(SAMPLE_FALL))
                rise_cnt <= rise_cnt + CNT_W'(1);
            if (scl_fall && fall_cnt != CNT_W'(SAMPLE_FALL))
                fall_cnt <= fall_cnt + CNT_W'(1);
        end
    end

    // track/hold level: tracking from the target rise to the sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            track <= 1'b0;
        else if (sample_go || start)
            track <= 1'b0;
        else if (track_go)
            track <= 1'b1;
    end

    // R2
    track_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(track) |-> $past(scl_rise));

endmodule

// File: rtl/scan_chan_walk.sv
// Maps the scan type, start channel, reference-pin bit and step index
// to the channel for that step, and flags the last step of the list.
// Assumes: the step index stays below the list length.
// Purely combinational.
module scan_chan_walk
    import scan_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int REPEAT_N = 8,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int IDX_W    = 3
) (
    input  logic [CH_W-1:0]  start_ch,
    input  scan_mode_e       mode,
    input  logic             ref_pin,
    input  logic [IDX_W-1:0] step,
    output logic [CH_W-1:0]  ch,
    output logic             last
);

    localparam int N_W = IDX_W + 1;

    logic [CH_W-1:0] top_ch;
    logic [CH_W-1:0] low_lim;
    logic [CH_W-1:0] base;
    logic            walk;
    logic [N_W-1:0]  count;

    // highest channel a multichannel scan may reach
    always_comb begin
        top_ch  = ref_pin ? CH_W'(NUM_CH - 2) : CH_W'(NUM_CH - 1);
        low_lim = (start_ch > top_ch) ? top_ch : start_ch;
    end

    // list shape per scan type
    always_comb begin
        unique case (mode)
            SCAN_UPTO: begin
                base  = '0;
                walk  = 1'b1;
                count = N_W'(low_lim) + N_W'(1);
            end
            SCAN_REPEAT: begin
                base  = start_ch;
                walk  = 1'b0;
                count = N_W'(REPEAT_N);
            end
            SCAN_FROM: begin
                base  = low_lim;
                walk  = 1'b1;
                count = N_W'(top_ch) - N_W'(low_lim) + N_W'(1);
            end
            default: begin
                base  = start_ch;
                walk  = 1'b0;
                count = N_W'(1);
            end
        endcase
    end

    // channel of this step and end-of-list flag
    always_comb begin
        ch   = base + (walk ? CH_W'(step) : '0);
        last = ({1'b0, step} == (count - N_W'(1)));
    end

endmodule

// File: rtl/scan_seq_top.sv
// Scan conversion sequencer for a serial-bus converter slave in internal-clock mode.
// Turns decoded bus events into track, sample and convert-start.
// Walks the channel list back to back and holds SCL low until the last result.
// Assumes: conv_done comes at least one cycle after conv_start.
module scan_seq_top
    import scan_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int REPEAT_N    = 8,
    parameter int TRACK_RISE  = 8,
    parameter int SAMPLE_FALL = 9,
    parameter int CH_W        = $clog2(NUM_CH),
    parameter int IDX_W       = $clog2((REPEAT_N > NUM_CH) ? REPEAT_N : NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CH_W-1:0]  cfg_start_ch,
    input  logic [1:0]       cfg_scan_type,
    input  logic             cfg_ref_pin,
    input  logic             cfg_clk_ext,
    input  logic             cfg_single_ended,
    input  logic             cfg_bipolar,
    input  logic             addr_rd_hit,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             conv_done,
    output logic             clk_mode,
    output logic             unipolar,
    output logic             track,
    output logic [CH_W-1:0]  ch_sel,
    output logic             conv_start,
    output logic             scl_hold,
    output logic             res_we,
    output logic [IDX_W-1:0] res_idx
);

    cfg_flags_t       flags_in;
    cfg_flags_t       flags_q;
    logic [CH_W-1:0]  start_q;
    logic             armed;
    logic             sample_go;
    logic             converting;
    logic             busy;
    logic             accept;
    logic [IDX_W-1:0] step;
    logic             last_step;

    // pack the configuration fields
    always_comb begin
        flags_in.mode         = scan_mode_e'(cfg_scan_type);
        flags_in.ref_pin      = cfg_ref_pin;
        flags_in.clk_ext      = cfg_clk_ext;
        flags_in.single_ended = cfg_single_ended;
        flags_in.bipolar      = cfg_bipolar;
    end

    // busy from address acceptance to SCL release; accept only when idle in internal mode
    always_comb begin
        busy   = armed | converting | scl_hold;
        accept = addr_rd_hit & ~busy & ~clk_mode;
    end

    scan_cfg_reg #(.CH_W(CH_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .busy     (busy),
        .start_in (cfg_start_ch),
        .flags_in (flags_in),
        .start_q  (start_q),
        .flags_q  (flags_q),
        .clk_mode (clk_mode),
        .unipolar (unipolar)
    );

    scan_edge_trig #(.TRACK_RISE(TRACK_RISE), .SAMPLE_FALL(SAMPLE_FALL)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .armed     (armed),
        .track     (track),
        .sample_go (sample_go)
    );

    scan_chan_walk #(.NUM_CH(NUM_CH), .REPEAT_N(REPEAT_N), .CH_W(CH_W), .IDX_W(IDX_W)) u_walk (
        .start_ch (start_q),
        .mode     (flags_q.mode),
        .ref_pin  (flags_q.ref_pin),
        .step     (step),
        .ch       (ch_sel),
        .last     (last_step)
    );

    // conversion sequencing and SCL stretch control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            converting <= 1'b0;
            step       <= '0;
            conv_start <= 1'b0;
            scl_hold   <= 1'b0;
            res_we     <= 1'b0;
            res_idx    <= '0;
        end else begin
            conv_start <= 1'b0;
            res_we     <= 1'b0;
            if (sample_go) begin
                converting <= 1'b1;
                step       <= '0;
                conv_start <= 1'b1;
                scl_hold   <= 1'b1;
            end else if (converting && conv_done) begin
                res_we  <= 1'b1;
                res_idx <= step;
                if (last_step) begin
                    converting <= 1'b0;
                    scl_hold   <= 1'b0;
                end else begin
                    step       <= step + IDX_W'(1);
                    conv_start <= 1'b1;
                end
            end
        end
    end

    // R3
    sample_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> (conv_start && !track));

    // R4
    start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> scl_hold);

    // R6
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_hold) |-> res_we);

    // R8
    ref_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && flags_q.ref_pin && !flags_q.mode[0]) |-> (ch_sel != CH_W'(NUM_CH - 1)));

endmodule

// File: tb/sim_scan_seq_top.sv
`timescale 1ns/1ps
module sim_scan_seq_top;

    localparam int CONV_CYCLES = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_start_ch = '0;
    logic [1:0] cfg_scan_type = '0;
    logic       cfg_ref_pin = 1'b0;
    logic       cfg_clk_ext = 1'b0;
    logic       cfg_single_ended = 1'b1;
    logic       cfg_bipolar = 1'b0;
    logic       addr_rd_hit = 1'b0;
    logic       scl_rise = 1'b0;
    logic       scl_fall = 1'b0;
    logic       conv_done;
    logic       clk_mode, unipolar, track, conv_start, scl_hold, res_we;
    logic [1:0] ch_sel;
    logic [2:0] res_idx;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // monitor state
    int ch_log [0:15];
    int idx_log [0:15];
    int n_start = 0;
    int n_res = 0;
    int hold_gap = 0;
    bit mon_on = 0;
    bit scan_end = 0;
    bit rel_ok = 0;
    int conv_cnt;

    always #5 clk = ~clk;

    scan_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start_ch(cfg_start_ch),
        .cfg_scan_type(cfg_scan_type), .cfg_ref_pin(cfg_ref_pin), .cfg_clk_ext(cfg_clk_ext),
        .cfg_single_ended(cfg_single_ended), .cfg_bipolar(cfg_bipolar),
        .addr_rd_hit(addr_rd_hit), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .conv_done(conv_done), .clk_mode(clk_mode), .unipolar(unipolar), .track(track),
        .ch_sel(ch_sel), .conv_start(conv_start), .scl_hold(scl_hold), .res_we(res_we),
        .res_idx(res_idx)
    );

    // fixed-latency converter model
    always @(posedge clk) begin
        if (!rst_n) begin
            conv_cnt  <= 0;
            conv_done <= 1'b0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start)
                conv_cnt <= CONV_CYCLES;
            else if (conv_cnt != 0) begin
                conv_cnt <= conv_cnt - 1;
                if (conv_cnt == 1)
                    conv_done <= 1'b1;
            end
        end
    end

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start) begin
                if (n_start < 16) ch_log[n_start] = int'(ch_sel);
                n_start++;
                mon_on = 1;
            end
            if (res_we) begin
                if (n_res < 16) idx_log[n_res] = int'(res_idx);
                n_res++;
            end
            if (mon_on && !scl_hold) begin
                if (res_we) rel_ok = 1;
                else hold_gap++;
                mon_on = 0;
                scan_end = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic pulse_rise();
        @(posedge clk); #1 scl_rise = 1'b1;
        @(posedge clk); #1 scl_rise = 1'b0;
    endtask

    task automatic pulse_fall();
        @(posedge clk); #1 scl_fall = 1'b1;
        @(posedge clk); #1 scl_fall = 1'b0;
    endtask

    task automatic load_cfg(input logic [1:0] m, input logic [1:0] st, input logic rp,
                            input logic ext, input logic se, input logic bp);
        @(posedge clk); #1;
        cfg_scan_type = m; cfg_start_ch = st; cfg_ref_pin = rp;
        cfg_clk_ext = ext; cfg_single_ended = se; cfg_bipolar = bp; cfg_load = 1'b1;
        @(posedge clk); #1 cfg_load = 1'b0;
    endtask

    task automatic clear_log();
        n_start = 0; n_res = 0; hold_gap = 0; scan_end = 0; rel_ok = 0; mon_on = 0;
    endtask

    // address then nine SCL clocks; timing checks when first_ch >= 0
    task automatic addr_clocks(input int first_ch);
        @(posedge clk); #1 addr_rd_hit = 1'b1;
        @(posedge clk); #1 addr_rd_hit = 1'b0;
        for (int i = 1; i <= 9; i++) begin
            pulse_rise();
            if (first_ch >= 0 && i == 7) chk(track == 1'b0, "R2 track before 8th rise", int'(track), 0);
            if (first_ch >= 0 && i == 8) chk(track == 1'b1, "R2 track at 8th rise", int'(track), 1);
            pulse_fall();
            if (first_ch >= 0 && i == 8) chk(conv_start == 1'b0 && scl_hold == 1'b0,
                                             "R3 no start at 8th fall", int'(conv_start), 0);
            if (first_ch >= 0 && i == 9) begin
                chk(track == 1'b0, "R3 track low after sample", int'(track), 0);
                chk(conv_start == 1'b1 && scl_hold == 1'b1, "R3 start and hold",
                    int'({conv_start, scl_hold}), 3);
                chk(int'(ch_sel) == first_ch, "R3 first channel", int'(ch_sel), first_ch);
            end
        end
    endtask

    task automatic wait_end();
        for (int i = 0; i < 3000 && !scan_end; i++) @(negedge clk);
    endtask

    // full scan with expected channel list (2 bits per entry, entry 0 lowest)
    task automatic run_scan(input logic [1:0] m, input logic [1:0] st, input logic rp,
                            input logic [15:0] chs, input int n, input string tag);
        load_cfg(m, st, rp, 1'b0, 1'b1, 1'b0);
        clear_log();
        addr_clocks(int'(chs[1:0]));
        wait_end();
        chk(n_start == n, {tag, " conversion count"}, n_start, n);
        chk(n_res == n, "R5 result count", n_res, n);
        for (int i = 0; i < n && i < 8; i++) begin
            chk(ch_log[i] == int'(chs[2*i +: 2]), tag, ch_log[i], int'(chs[2*i +: 2]));
            chk(idx_log[i] == i, "R5 result index", idx_log[i], i);
        end
        chk(hold_gap == 0, "R4 hold kept", hold_gap, 0);
        chk(rel_ok == 1, "R6 release with last result", int'(rel_ok), 1);
    endtask

    task automatic test_reset();
        chk(clk_mode == 1'b0, "R1 clock mode", int'(clk_mode), 0);
        chk(scl_hold == 1'b0, "R1 hold", int'(scl_hold), 0);
        chk(track == 1'b0, "R1 track", int'(track), 0);
        chk(conv_start == 1'b0, "R1 start", int'(conv_start), 0);
    endtask

    task automatic test_coding();
        load_cfg(2'b11, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(unipolar == 1'b1, "R9 single-ended bipolar", int'(unipolar), 1);
        load_cfg(2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(unipolar == 1'b0, "R9 differential bipolar", int'(unipolar), 0);
        load_cfg(2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(unipolar == 1'b1, "R9 differential unipolar", int'(unipolar), 1);
    endtask

    task automatic test_busy_ignore();
        load_cfg(2'b01, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
        clear_log();
        addr_clocks(2);
        addr_clocks(-1);
        load_cfg(2'b11, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        wait_end();
        chk(n_start == 8, "R10 scan unchanged", n_start, 8);
        chk(clk_mode == 1'b0, "R10 load ignored", int'(clk_mode), 0);
        repeat (40) @(negedge clk);
        chk(n_start == 8 && track == 1'b0, "R10 no second scan", n_start, 8);
    endtask

    task automatic test_ext_mode();
        load_cfg(2'b11, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        chk(clk_mode == 1'b1, "R11 clock mode loaded", int'(clk_mode), 1);
        clear_log();
        addr_clocks(-1);
        repeat (20) @(negedge clk);
        chk(track == 1'b0 && n_start == 0, "R11 nothing started", n_start, 0);
        load_cfg(2'b11, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset();
        run_scan(2'b00, 2'd2, 1'b0, 16'h0024, 3, "R7 type 00 start 2");
        run_scan(2'b00, 2'd3, 1'b0, 16'h00E4, 4, "R7 type 00 start 3");
        run_scan(2'b00, 2'd3, 1'b1, 16'h0024, 3, "R8 type 00 limited");
        run_scan(2'b10, 2'd1, 1'b0, 16'h0039, 3, "R7 type 10 start 1");
        run_scan(2'b10, 2'd1, 1'b1, 16'h0009, 2, "R8 type 10 limited");
        run_scan(2'b01, 2'd3, 1'b1, 16'hFFFF, 8, "R7 type 01 repeat");
        run_scan(2'b11, 2'd3, 1'b1, 16'h0003, 1, "R7 type 11 single ch3");
        run_scan(2'b11, 2'd0, 1'b0, 16'h0000, 1, "R7 type 11 single ch0");
        test_coding();
        test_busy_ignore();
        test_ext_mode();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule